// File: doc/BRIEF.md
# Dual-Strobe Reversible Counter Stage

This block is a small binary counter that is stepped by two independent count strobes instead of a clock plus a direction bit. A rising edge on the up strobe adds one, a rising edge on the down strobe subtracts one, and each edge only counts while the opposite strobe rests high. A level-sensitive clear and an active-low parallel preset override all counting. Both strobes, clear, preset and the preset data are brought into the system clock domain through synchronizers and treated as sampled levels.

Two active-low terminal outputs mirror the low phase of the active strobe when the count sits at the top or the bottom of its range. Because they reproduce the strobe waveform, they can drive the up and down strobes of a following stage directly, which builds a wider ripple counter from identical stages. A rising edge seen on one strobe while the other is low is treated as a protocol violation: the count holds and a one-cycle error flag is raised.

Top module: `updn_counter_stage`

## Requirements
- R1: A rising edge on `upStrobe` while `dnStrobe` is high raises `count` by one, wrapping from 15 to 0; `count` shows the new value three system clock edges after the edge is applied.
- R2: A rising edge on `dnStrobe` while `upStrobe` is high lowers `count` by one, wrapping from 0 to 15, with the same latency as R1.
- R3: While `clearIn` (active high) is 1, `count` becomes 0 regardless of `loadN`, `dataIn` and both strobes.
- R4: While `loadN` is 0 (active low) and `clearIn` is 0, `count` follows `dataIn` regardless of the strobes.
- R5: `carryN` is 0 only while `count` is 15 and `upStrobe` is held low; otherwise it is 1.
- R6: `borrowN` is 0 only while `count` is 0 and `dnStrobe` is held low; otherwise it is 1.
- R7: A strobe held low through a clear or preset and released afterwards has its first rising edge counted.
- R8: A rising edge on one strobe while the other strobe is low leaves `count` unchanged and drives `seqError` to 1 for exactly one system clock cycle.
- R9: Two stages with `carryN`/`borrowN` of the lower stage wired to `upStrobe`/`dnStrobe` of the upper stage count as one 8-bit counter in both directions, including across the 0x0F/0x10 and 0xFF/0x00 boundaries.
- R10: After `rst_n` is released, `count` is 0, `carryN` and `borrowN` are 1 and `seqError` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| upStrobe | input | 1 | Count-up strobe, acts on its rising edge |
| dnStrobe | input | 1 | Count-down strobe, acts on its rising edge |
| clearIn | input | 1 | Active-high level clear, highest priority |
| loadN | input | 1 | Active-low level preset |
| dataIn | input | WIDTH | Preset value |
| count | output | WIDTH | Current count |
| carryN | output | 1 | Active-low carry, low phase of the up strobe at the top count |
| borrowN | output | 1 | Active-low borrow, low phase of the down strobe at count zero |
| seqError | output | 1 | One-cycle flag for an edge arriving while the other strobe is low |

## Verification
The assertions assume that every strobe level, clear and preset is held for at least two system clock cycles so that the synchronized copy matches the pin, and that strobes idle high during and just after reset. The stimulus keeps every strobe low phase at four cycles and every high phase at eight, changes inputs only on the falling clock edge, and drives the two strobes low together only where the protocol violation is being exercised. The cascade pulses are stretched enough for the second stage to see each copied strobe edge after its own synchronizer delay.

// File: rtl/updn_pkg.sv
package updn_pkg;
  // Per-cycle commands handed from control to datapath.
  typedef struct packed {
    logic clear;
    logic load;
    logic inc;
    logic dec;
    logic err;
    logic upLevel;
    logic dnLevel;
  } cmd_t;
endpackage

// File: rtl/updn_sync.sv
module updn_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
    end else begin
      pipe[0] <= din;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upStrobe,
  input  logic             dnStrobe,
  input  logic             clearIn,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  output cmd_t             cmd,
  output logic [WIDTH-1:0] loadData
);
  localparam int VW = WIDTH + 4;
  localparam logic [VW-1:0] IDLE = {1'b1, 1'b1, 1'b0, 1'b1, {WIDTH{1'b0}}};

  logic [VW-1:0] rawVec, syncVec;
  logic upS, dnS, clrS, loadNS;
  logic upPrev, dnPrev;
  logic upRise, dnRise;

  assign rawVec = {upStrobe, dnStrobe, clearIn, loadN, dataIn};

  updn_sync #(.W(VW), .STAGES(SYNC_STAGES), .INIT(IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rawVec),
    .dout (syncVec)
  );

  assign {upS, dnS, clrS, loadNS, loadData} = syncVec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upPrev <= 1'b1;
      dnPrev <= 1'b1;
    end else begin
      upPrev <= upS;
      dnPrev <= dnS;
    end
  end

  assign upRise = upS & ~upPrev;
  assign dnRise = dnS & ~dnPrev;

  always_comb begin
    cmd         = '0;
    cmd.clear   = clrS;
    cmd.load    = ~loadNS & ~clrS;
    cmd.upLevel = upS;
    cmd.dnLevel = dnS;
    // Simultaneous rises mean both strobes were low together: invalid.
    cmd.err     = (upRise & ~dnS) | (dnRise & ~upS) | (upRise & dnRise);
    cmd.inc     = upRise & dnS & ~dnRise & ~clrS & loadNS;
    cmd.dec     = dnRise & upS & ~upRise & ~clrS & loadNS;
  end
endmodule

// File: rtl/updn_datapath.sv
module updn_datapath
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cmd_t             cmd,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          count <= '0;
    else if (cmd.clear)  count <= '0;
    else if (cmd.load)   count <= loadData;
    else if (cmd.inc)    count <= count + 1'b1;
    else if (cmd.dec)    count <= count - 1'b1;
  end

  assign carryN  = ~((count == TOP) & ~cmd.upLevel);
  assign borrowN = ~((count == '0)  & ~cmd.dnLevel);
endmodule

// File: rtl/updn_counter_stage.sv
module updn_counter_stage
  import updn_pkg::*;
#(
  parameter int WIDTH = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upStrobe,
  input  logic             dnStrobe,
  input  logic             clearIn,
  input  logic             loadN,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             carryN,
  output logic             borrowN,
  output logic             seqError
);
  cmd_t             cmd;
  logic [WIDTH-1:0] loadData;

  updn_ctrl #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .upStrobe(upStrobe),
    .dnStrobe(dnStrobe),
    .clearIn (clearIn),
    .loadN   (loadN),
    .dataIn  (dataIn),
    .cmd     (cmd),
    .loadData(loadData)
  );

  updn_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd     (cmd),
    .loadData(loadData),
    .count   (count),
    .carryN  (carryN),
    .borrowN (borrowN)
  );

  assign seqError = cmd.err;
endmodule

// File: rtl/updn_counter_stage_chk.sv
module updn_counter_stage_chk
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upStrobe,
  input logic             dnStrobe,
  input cmd_t             cmd,
  input logic [WIDTH-1:0] loadData,
  input logic [WIDTH-1:0] count,
  input logic             carryN,
  input logic             borrowN,
  input logic             seqError
);
  localparam logic [WIDTH-1:0] TOP = {WIDTH{1'b1}};

  p_clear_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.clear |=> count == '0);

  p_load_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.load && !cmd.clear) |=> count == $past(loadData));

  p_inc_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.inc |=> count == WIDTH'($past(count) + 1'b1));

  p_dec_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.dec |=> count == WIDTH'($past(count) - 1'b1));

  p_err_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (seqError && !cmd.clear && !cmd.load) |=> $stable(count));

  p_err_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    seqError |=> !seqError);

  p_carry_top_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !carryN |-> (count == TOP) && !$past(upStrobe, 2));

  p_borrow_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !borrowN |-> (count == '0) && !$past(dnStrobe, 2));
endmodule

bind updn_counter_stage updn_counter_stage_chk #(.WIDTH(WIDTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .upStrobe(upStrobe),
  .dnStrobe(dnStrobe),
  .cmd     (cmd),
  .loadData(loadData),
  .count   (count),
  .carryN  (carryN),
  .borrowN (borrowN),
  .seqError(seqError)
);

// File: tb/updn_counter_stage_tb.sv
module updn_counter_stage_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  // Single stage under test
  logic       upS = 1'b1, dnS = 1'b1, clr = 1'b0, ldN = 1'b1;
  logic [3:0] din = '0;
  logic [3:0] cnt;
  logic       carN, borN, err;

  updn_counter_stage u_dut (
    .clk(clk), .rst_n(rst_n), .upStrobe(upS), .dnStrobe(dnS),
    .clearIn(clr), .loadN(ldN), .dataIn(din),
    .count(cnt), .carryN(carN), .borrowN(borN), .seqError(err)
  );

  // Two-stage ripple cascade
  logic       cUp = 1'b1, cDn = 1'b1, cClr = 1'b0, cLdN = 1'b1;
  logic [7:0] cData = '0;
  logic [3:0] loCnt, hiCnt;
  logic       loCar, loBor, hiCar, hiBor, loErr, hiErr;

  updn_counter_stage u_lo (
    .clk(clk), .rst_n(rst_n), .upStrobe(cUp), .dnStrobe(cDn),
    .clearIn(cClr), .loadN(cLdN), .dataIn(cData[3:0]),
    .count(loCnt), .carryN(loCar), .borrowN(loBor), .seqError(loErr)
  );
  updn_counter_stage u_hi (
    .clk(clk), .rst_n(rst_n), .upStrobe(loCar), .dnStrobe(loBor),
    .clearIn(cClr), .loadN(cLdN), .dataIn(cData[7:4]),
    .count(hiCnt), .carryN(hiCar), .borrowN(hiBor), .seqError(hiErr)
  );

  int nChecks = 0;
  int nFail = 0;
  int errCnt = 0;
  int cascErr = 0;
  logic [3:0] model;
  logic [7:0] cModel;

  always @(posedge clk) begin
    if (err) errCnt++;
    if (loErr || hiErr) cascErr++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_up();
    upS = 1'b0;
    wait_n(4);
    chk("R5 carryN during up low", {31'b0, carN}, (model == 4'hF) ? 0 : 1);
    upS = 1'b1;
    model = model + 1'b1;
    wait_n(8);
    chk("R1 count after up edge", {28'b0, cnt}, {28'b0, model});
  endtask

  task automatic pulse_dn();
    dnS = 1'b0;
    wait_n(4);
    chk("R6 borrowN during down low", {31'b0, borN}, (model == 4'h0) ? 0 : 1);
    dnS = 1'b1;
    model = model - 1'b1;
    wait_n(8);
    chk("R2 count after down edge", {28'b0, cnt}, {28'b0, model});
  endtask

  task automatic casc_load(input logic [7:0] v);
    cData = v;
    cLdN = 1'b0;
    wait_n(5);
    cLdN = 1'b1;
    wait_n(5);
    cModel = v;
    chk("R9 cascade preset", {24'b0, hiCnt, loCnt}, {24'b0, cModel});
  endtask

  task automatic casc_up();
    cUp = 1'b0;
    wait_n(4);
    cUp = 1'b1;
    wait_n(10);
    cModel = cModel + 1'b1;
    chk("R9 cascade up", {24'b0, hiCnt, loCnt}, {24'b0, cModel});
  endtask

  task automatic casc_dn();
    cDn = 1'b0;
    wait_n(4);
    cDn = 1'b1;
    wait_n(10);
    cModel = cModel - 1'b1;
    chk("R9 cascade down", {24'b0, hiCnt, loCnt}, {24'b0, cModel});
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int base;
    wait_n(4);
    rst_n = 1'b1;
    wait_n(3);
    // R10 reset state
    chk("R10 count after reset", {28'b0, cnt}, 0);
    chk("R10 carryN after reset", {31'b0, carN}, 1);
    chk("R10 borrowN after reset", {31'b0, borN}, 1);
    chk("R10 seqError after reset", {31'b0, err}, 0);
    model = 4'h0;

    // R1 / R5: up sweep with wrap
    for (int i = 0; i < 18; i++) pulse_up();
    // R2 / R6: down sweep with wrap
    for (int i = 0; i < 18; i++) pulse_dn();

    // R4 / R7: preset every value with the up strobe held low, then release
    for (int v = 0; v < 16; v++) begin
      upS = 1'b0;
      din = 4'(v);
      ldN = 1'b0;
      wait_n(5);
      chk("R4 preset value", {28'b0, cnt}, v);
      chk("R5 carryN at preset top", {31'b0, carN}, (v == 15) ? 0 : 1);
      din = 4'(v + 5);
      ldN = 1'b1;
      wait_n(5);
      chk("R4 held after preset release", {28'b0, cnt}, v);
      upS = 1'b1;
      wait_n(8);
      model = 4'(v + 1);
      chk("R7 first edge after preset", {28'b0, cnt}, {28'b0, model});
    end

    // R3 / R7: clear beats preset, down strobe low across clear
    dnS = 1'b0;
    din = 4'h9;
    ldN = 1'b0;
    clr = 1'b1;
    wait_n(5);
    chk("R3 clear overrides preset", {28'b0, cnt}, 0);
    ldN = 1'b1;
    wait_n(2);
    clr = 1'b0;
    wait_n(5);
    chk("R3 zero after clear release", {28'b0, cnt}, 0);
    chk("R6 borrowN low at zero", {31'b0, borN}, 0);
    dnS = 1'b1;
    wait_n(8);
    model = 4'hF;
    chk("R7 first edge after clear", {28'b0, cnt}, {28'b0, model});

    // R8: up edge while down is low is ignored and flagged once
    din = 4'h5;
    ldN = 1'b0;
    wait_n(5);
    ldN = 1'b1;
    dnS = 1'b0;
    wait_n(5);
    base = errCnt;
    upS = 1'b0;
    wait_n(4);
    upS = 1'b1;
    wait_n(8);
    chk("R8 count held on bad edge", {28'b0, cnt}, 5);
    chk("R8 seqError one cycle", errCnt - base, 1);
    dnS = 1'b1;
    wait_n(8);
    chk("R2 down edge after violation", {28'b0, cnt}, 4);
    chk("R8 no flag on valid edge", errCnt - base, 1);

    // R9: cascade across nibble boundaries both ways
    casc_load(8'h0C);
    for (int i = 0; i < 7; i++) casc_up();
    for (int i = 0; i < 7; i++) casc_dn();
    casc_load(8'hFC);
    for (int i = 0; i < 6; i++) casc_up();
    for (int i = 0; i < 6; i++) casc_dn();
    chk("R9 cascade free of violations", cascErr, 0);

    finish_run();
  end
endmodule